// File: doc/BRIEF.md
# Atomic Semaphore Read-Modify-Write Unit

This unit carries out one atomic semaphore operation at a time: exchange, compare-exchange or fetch-and-add. It works against a simple item-level memory port. Each accepted request is first screened against legality rules. The rules cover the memory attribute, natural alignment to the access size, and a lock-control bit that applies to legacy locked accesses. A request that breaks a rule ends with a single fault code and touches nothing. A legal request reads the location, computes the new value and writes it back, and the `mem_lock` output is held high across that read and write so that no other access can fall between them. A fetch-and-add to an exported-uncacheable location is not done locally. When the unit is built with export support, the request goes to the platform through an export handshake.

Requests enter on a valid/ready handshake. `req_ready` is high only while the unit is idle, and it drops for the whole of an operation. A requester that holds `req_valid` high simply waits, and its fields must stay steady until acceptance. The result comes back as a one-cycle `rsp_valid` pulse, with no back-pressure. The memory port and the export port each use their own valid/ready pair. The memory port stalls a command for as long as `mem_cmd_ready` is low. The export port stalls on `exp_ready`, and the platform later signals completion with a one-cycle `exp_done` pulse.

Top module: `sem_rmw_unit`

## Requirements
- R1: `req_ready` is high only when idle. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle after acceptance and stays low until `rsp_valid` has pulsed for one cycle.
- R2: Exchange (op code 0) writes the operand, truncated to the access size, and returns the old value. Its `rsp_acquire` is always 1.
- R3: Compare-exchange (op code 1) writes the operand only when the old value equals the compare input, both truncated to the access size. It always returns the old value.
- R4: Fetch-and-add (op code 2) writes old plus operand, modulo 2^(8 × access bytes).
- R5: For compare-exchange and fetch-and-add without a fault, `rsp_acquire` equals the `req_acquire` that was accepted with the request. On any fault, `rsp_acquire` is 0.
- R6: `mem_lock` is high from the read command through the write command. The address stays steady while it is high, and a legal local request issues exactly one read and then either one write or, for a failed compare, none.
- R7: Attribute codes are 0 write-back, 1 uncacheable, 2 exported-uncacheable and 3 write-combining. Only write-back is legal, with a single exception: fetch-and-add may target exported-uncacheable when export support is built in. Any other attribute, and op code 3, reports fault code 2 (unsupported reference).
- R8: An aligned fetch-and-add to exported-uncacheable, with export support built in and no other fault, issues exactly one export request, makes no memory access and returns `exp_old` as the old value. Without export support the same request reports fault code 2.
- R9: An address whose low log2(bytes) bits are not all zero reports fault code 3 (unaligned), whatever the value of `req_align_chk`. Size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes.
- R10: When `req_legacy_lock` and `ctl_lock_icpt` are both 1 and the access is either not write-back or misaligned, fault code 1 (lock intercept) is reported.
- R11: Exactly one fault code is reported, with priority lock intercept, then unsupported reference, then unaligned. Code 0 means no fault.
- R12: A faulting request makes no memory or export command. `rsp_valid` rises in the cycle after acceptance, and `rsp_old` is 0.
- R13: After reset, `req_ready` is 1 and `rsp_valid`, `mem_cmd_valid`, `mem_lock` and `exp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 2 | 0 exchange, 1 compare-exchange, 2 fetch-and-add, 3 reserved |
| req_addr | input | ADDR_W | Byte address of the item |
| req_size | input | 2 | log2 of access bytes |
| req_operand | input | DATA_W | Exchange/compare-exchange new value or addend |
| req_cmp | input | DATA_W | Compare value |
| req_acquire | input | 1 | Acquire wanted for compare-exchange/fetch-and-add |
| req_attr | input | 2 | Memory attribute code |
| req_legacy_lock | input | 1 | Request is a legacy locked access |
| ctl_lock_icpt | input | 1 | Lock-control bit |
| req_align_chk | input | 1 | User alignment-check enable (has no effect) |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_old | output | DATA_W | Old value read |
| rsp_acquire | output | 1 | Acquire indication |
| rsp_fault | output | 2 | Fault code |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory command accepted |
| mem_cmd_write | output | 1 | 1 write, 0 read |
| mem_lock | output | 1 | Hold memory for the atomic sequence |
| mem_addr | output | ADDR_W | Item address |
| mem_size | output | 2 | Size code |
| mem_wdata | output | DATA_W | Write item, low bytes |
| mem_rdata | input | DATA_W | Read item, valid when a read is accepted |
| exp_valid | output | 1 | Export fetch-and-add request |
| exp_ready | input | 1 | Platform took the export request |
| exp_addr | output | ADDR_W | Export address |
| exp_size | output | 2 | Export size code |
| exp_operand | output | DATA_W | Export addend |
| exp_done | input | 1 | Platform completion pulse |
| exp_old | input | DATA_W | Old value from the platform |

## Verification
The main instance is built with the defaults: 32-bit address, 64-bit data and export support on. This lets fetch-and-add to exported-uncacheable reach the export handshake, and all four sizes reach byte wrap and 8-byte arithmetic. A second instance is built with export support off. It brings within reach the case where the same exported fetch-and-add must fault as unsupported. Random memory and export stalls stretch the locked window between the read and the write.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {OP_XCHG = 2'd0, OP_CMPXCHG = 2'd1, OP_FETCHADD = 2'd2, OP_RSVD = 2'd3} sem_op_e;
  typedef enum logic [1:0] {ATTR_WB = 2'd0, ATTR_UC = 2'd1, ATTR_UCE = 2'd2, ATTR_WC = 2'd3} sem_attr_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_LOCK = 2'd1, FLT_UNSUP = 2'd2, FLT_UNALIGN = 2'd3} sem_fault_e;
  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_WRITE, ST_EXP_REQ, ST_EXP_WAIT, ST_DONE} sem_state_e;
endpackage

// File: rtl/sem_legality.sv
module sem_legality
  import sem_pkg::*;
#(
  parameter bit EXPORT_FA = 1'b1
) (
  input  logic [1:0] op_i,
  input  logic [2:0] addr_lo_i,
  input  logic [1:0] size_i,
  input  logic [1:0] attr_i,
  input  logic       legacy_lock_i,
  input  logic       lock_ctl_i,
  input  logic       align_chk_i,
  output logic [1:0] fault_o,
  output logic       export_o
);
  logic [2:0] low_mask;
  logic       misaligned, cacheable, uce_fa_ok, lock_hit, unsup;
  logic       unused_align_chk;

  assign unused_align_chk = align_chk_i;  // alignment faults never depend on it

  always_comb begin
    low_mask   = 3'((4'd1 << size_i) - 4'd1);
    misaligned = |(addr_lo_i & low_mask);
    cacheable  = (attr_i == ATTR_WB);
    uce_fa_ok  = EXPORT_FA && (op_i == OP_FETCHADD) && (attr_i == ATTR_UCE);
    unsup      = (op_i == OP_RSVD) || !(cacheable || uce_fa_ok);
    lock_hit   = legacy_lock_i && lock_ctl_i && (!cacheable || misaligned);
    if (lock_hit)        fault_o = FLT_LOCK;
    else if (unsup)      fault_o = FLT_UNSUP;
    else if (misaligned) fault_o = FLT_UNALIGN;
    else                 fault_o = FLT_NONE;
    export_o = uce_fa_ok && (fault_o == FLT_NONE);
  end

  always_comb begin
    if (fault_o == FLT_NONE) begin
      assert_clean_is_aligned_R9: assert (!misaligned);
    end
  end
endmodule

// File: rtl/sem_modify.sv
module sem_modify
  import sem_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] cmp_i,
  output logic [DATA_W-1:0] old_o,
  output logic [DATA_W-1:0] new_o,
  output logic              write_o
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] mask, opnd_m;

  always_comb begin
    mask = '0;
    for (int b = 0; b < NBYTES; b++) begin
      mask[b*8 +: 8] = (b < (1 << size_i)) ? 8'hFF : 8'h00;
    end
    old_o  = rdata_i & mask;
    opnd_m = operand_i & mask;
    case (op_i)
      OP_XCHG:     begin new_o = opnd_m;                   write_o = 1'b1; end
      OP_CMPXCHG:  begin new_o = opnd_m;                   write_o = (old_o == (cmp_i & mask)); end
      OP_FETCHADD: begin new_o = (old_o + opnd_m) & mask;  write_o = 1'b1; end
      default:     begin new_o = old_o;                    write_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/sem_seq.sv
module sem_seq
  import sem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_operand_i,
  input  logic [DATA_W-1:0] req_cmp_i,
  input  logic              req_acq_i,
  input  logic [1:0]        chk_fault_i,
  input  logic              chk_export_i,
  output logic [1:0]        cur_op_o,
  output logic [1:0]        cur_size_o,
  output logic [DATA_W-1:0] cur_operand_o,
  output logic [DATA_W-1:0] cur_cmp_o,
  input  logic [DATA_W-1:0] mod_old_i,
  input  logic [DATA_W-1:0] mod_new_i,
  input  logic              mod_write_i,
  output logic              mem_cmd_valid_o,
  input  logic              mem_cmd_ready_i,
  output logic              mem_cmd_write_o,
  output logic              mem_lock_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              exp_valid_o,
  input  logic              exp_ready_i,
  output logic [ADDR_W-1:0] exp_addr_o,
  output logic [1:0]        exp_size_o,
  output logic [DATA_W-1:0] exp_operand_o,
  input  logic              exp_done_i,
  input  logic [DATA_W-1:0] exp_old_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_old_o,
  output logic              rsp_acquire_o,
  output logic [1:0]        rsp_fault_o
);
  sem_state_e        st;
  logic [1:0]        op_q, size_q, fault_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opnd_q, cmp_q, old_q, new_q;
  logic              acq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op_q    <= '0;
      size_q  <= '0;
      fault_q <= '0;
      addr_q  <= '0;
      opnd_q  <= '0;
      cmp_q   <= '0;
      old_q   <= '0;
      new_q   <= '0;
      acq_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid_i) begin
          op_q    <= req_op_i;
          size_q  <= req_size_i;
          addr_q  <= req_addr_i;
          opnd_q  <= req_operand_i;
          cmp_q   <= req_cmp_i;
          acq_q   <= req_acq_i;
          fault_q <= chk_fault_i;
          old_q   <= '0;
          if (chk_fault_i != FLT_NONE) st <= ST_DONE;
          else if (chk_export_i)       st <= ST_EXP_REQ;
          else                         st <= ST_READ;
        end
        ST_READ: if (mem_cmd_ready_i) begin
          old_q <= mod_old_i;
          new_q <= mod_new_i;
          st    <= mod_write_i ? ST_WRITE : ST_DONE;
        end
        ST_WRITE:    if (mem_cmd_ready_i) st <= ST_DONE;
        ST_EXP_REQ:  if (exp_ready_i) st <= ST_EXP_WAIT;
        ST_EXP_WAIT: if (exp_done_i) begin
          old_q <= exp_old_i;
          st    <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (st == ST_IDLE);
  assign cur_op_o        = op_q;
  assign cur_size_o      = size_q;
  assign cur_operand_o   = opnd_q;
  assign cur_cmp_o       = cmp_q;
  assign mem_cmd_valid_o = (st == ST_READ) || (st == ST_WRITE);
  assign mem_cmd_write_o = (st == ST_WRITE);
  assign mem_lock_o      = mem_cmd_valid_o;
  assign mem_addr_o      = addr_q;
  assign mem_size_o      = size_q;
  assign mem_wdata_o     = new_q;
  assign exp_valid_o     = (st == ST_EXP_REQ);
  assign exp_addr_o      = addr_q;
  assign exp_size_o      = size_q;
  assign exp_operand_o   = opnd_q;
  assign rsp_valid_o     = (st == ST_DONE);
  assign rsp_old_o       = old_q;
  assign rsp_fault_o     = fault_q;
  assign rsp_acquire_o   = rsp_valid_o && (fault_q == FLT_NONE) && ((op_q == OP_XCHG) || acq_q);

  assert_busy_blocks_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_done_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);
  assert_write_inside_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid_o && mem_cmd_write_o) |-> (mem_lock_o && $past(mem_lock_o)));
  assert_lock_addr_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock_o && $past(mem_lock_o)) |-> $stable(mem_addr_o));
  assert_fault_no_traffic_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid_o || exp_valid_o) |-> (fault_q == FLT_NONE));
  assert_fault_next_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && (chk_fault_i != FLT_NONE))
      |=> (rsp_valid_o && (rsp_fault_o == $past(chk_fault_i)) && !rsp_acquire_o));
endmodule

// File: rtl/sem_rmw_unit.sv
module sem_rmw_unit
  import sem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter bit EXPORT_FA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [DATA_W-1:0] req_cmp,
  input  logic              req_acquire,
  input  logic [1:0]        req_attr,
  input  logic              req_legacy_lock,
  input  logic              ctl_lock_icpt,
  input  logic              req_align_chk,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_old,
  output logic              rsp_acquire,
  output logic [1:0]        rsp_fault,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_write,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              exp_valid,
  input  logic              exp_ready,
  output logic [ADDR_W-1:0] exp_addr,
  output logic [1:0]        exp_size,
  output logic [DATA_W-1:0] exp_operand,
  input  logic              exp_done,
  input  logic [DATA_W-1:0] exp_old
);
  logic [1:0]        chk_fault, cur_op, cur_size;
  logic              chk_export, mod_write;
  logic [DATA_W-1:0] cur_operand, cur_cmp, mod_old, mod_new;

  sem_legality #(.EXPORT_FA(EXPORT_FA)) u_legal (
    .op_i(req_op), .addr_lo_i(req_addr[2:0]), .size_i(req_size), .attr_i(req_attr),
    .legacy_lock_i(req_legacy_lock), .lock_ctl_i(ctl_lock_icpt), .align_chk_i(req_align_chk),
    .fault_o(chk_fault), .export_o(chk_export)
  );

  sem_modify #(.DATA_W(DATA_W)) u_modify (
    .op_i(cur_op), .size_i(cur_size), .rdata_i(mem_rdata), .operand_i(cur_operand),
    .cmp_i(cur_cmp), .old_o(mod_old), .new_o(mod_new), .write_o(mod_write)
  );

  sem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_operand_i(req_operand),
    .req_cmp_i(req_cmp), .req_acq_i(req_acquire),
    .chk_fault_i(chk_fault), .chk_export_i(chk_export),
    .cur_op_o(cur_op), .cur_size_o(cur_size), .cur_operand_o(cur_operand), .cur_cmp_o(cur_cmp),
    .mod_old_i(mod_old), .mod_new_i(mod_new), .mod_write_i(mod_write),
    .mem_cmd_valid_o(mem_cmd_valid), .mem_cmd_ready_i(mem_cmd_ready),
    .mem_cmd_write_o(mem_cmd_write), .mem_lock_o(mem_lock), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata),
    .exp_valid_o(exp_valid), .exp_ready_i(exp_ready), .exp_addr_o(exp_addr),
    .exp_size_o(exp_size), .exp_operand_o(exp_operand), .exp_done_i(exp_done),
    .exp_old_i(exp_old),
    .rsp_valid_o(rsp_valid), .rsp_old_o(rsp_old), .rsp_acquire_o(rsp_acquire),
    .rsp_fault_o(rsp_fault)
  );
endmodule

// File: tb/sem_rmw_unit_tb_top.sv
module sem_rmw_unit_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        req_valid = 1'b0, nx_valid = 1'b0;
  logic [1:0]  req_op = '0, req_size = '0, req_attr = '0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_operand = '0, req_cmp = '0;
  logic        req_acquire = 1'b0, req_legacy_lock = 1'b0, ctl_lock_icpt = 1'b0, req_align_chk = 1'b0;

  logic        req_ready, rsp_valid, rsp_acquire, mem_cmd_valid, mem_cmd_write, mem_lock, exp_valid;
  logic [63:0] rsp_old, mem_wdata, exp_operand, mem_rdata;
  logic [1:0]  rsp_fault, mem_size, exp_size;
  logic [31:0] mem_addr, exp_addr;
  logic        mem_cmd_ready = 1'b0, exp_ready = 1'b0, exp_done = 1'b0;
  logic [63:0] exp_old = '0;

  logic        nx_ready, nx_rsp_valid, nx_acq, nx_mv, nx_mw, nx_ml, nx_ev;
  logic [63:0] nx_old, nx_wd, nx_eo;
  logic [1:0]  nx_fault, nx_ms, nx_es;
  logic [31:0] nx_ma, nx_ea;

  sem_rmw_unit dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr, .req_size, .req_operand,
    .req_cmp, .req_acquire, .req_attr, .req_legacy_lock, .ctl_lock_icpt, .req_align_chk,
    .rsp_valid, .rsp_old, .rsp_acquire, .rsp_fault, .mem_cmd_valid, .mem_cmd_ready,
    .mem_cmd_write, .mem_lock, .mem_addr, .mem_size, .mem_wdata, .mem_rdata,
    .exp_valid, .exp_ready, .exp_addr, .exp_size, .exp_operand, .exp_done, .exp_old
  );

  sem_rmw_unit #(.EXPORT_FA(1'b0)) dut_nx_i (
    .clk, .rst_n, .req_valid(nx_valid), .req_ready(nx_ready), .req_op, .req_addr, .req_size,
    .req_operand, .req_cmp, .req_acquire, .req_attr, .req_legacy_lock, .ctl_lock_icpt,
    .req_align_chk, .rsp_valid(nx_rsp_valid), .rsp_old(nx_old), .rsp_acquire(nx_acq),
    .rsp_fault(nx_fault), .mem_cmd_valid(nx_mv), .mem_cmd_ready(1'b1), .mem_cmd_write(nx_mw),
    .mem_lock(nx_ml), .mem_addr(nx_ma), .mem_size(nx_ms), .mem_wdata(nx_wd),
    .mem_rdata(64'd0), .exp_valid(nx_ev), .exp_ready(1'b1), .exp_addr(nx_ea),
    .exp_size(nx_es), .exp_operand(nx_eo), .exp_done(1'b0), .exp_old(64'd0)
  );

  // Byte-wide memory model (256 bytes, addresses wrap)
  logic [7:0] mem_b [0:255];
  int mem_cnt = 0, exp_cnt = 0;
  bit pend = 1'b0;
  int dly = 0;
  int tests = 0, fails = 0;

  always_comb begin
    for (int i = 0; i < 8; i++) mem_rdata[i*8 +: 8] = mem_b[8'(mem_addr[7:0] + 8'(i))];
  end

  function automatic logic [63:0] plat_val(logic [31:0] a);
    return 64'hA5C3_0000_0000_0000 | 64'(a);
  endfunction

  always @(posedge clk) begin
    if (mem_cmd_valid && mem_cmd_ready) begin
      mem_cnt++;
      if (mem_cmd_write)
        for (int i = 0; i < (1 << mem_size); i++) mem_b[8'(mem_addr[7:0] + 8'(i))] = mem_wdata[i*8 +: 8];
    end
    mem_cmd_ready <= ($urandom % 4) != 0;
    exp_ready     <= ($urandom % 3) != 0;
    if (exp_done) exp_done <= 1'b0;
    if (exp_valid && exp_ready) begin
      exp_cnt++;
      pend = 1'b1;
      dly  = $urandom % 3;
    end else if (pend) begin
      if (dly == 0) begin
        exp_done <= 1'b1;
        exp_old  <= plat_val(exp_addr);
        pend = 1'b0;
      end else dly--;
    end
  end

  function automatic logic [63:0] szmask(logic [1:0] s);
    logic [63:0] m = '0;
    for (int b = 0; b < 8; b++) if (b < (1 << s)) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [1:0] ref_fault(logic [1:0] op, logic [31:0] a, logic [1:0] s,
                                           logic [1:0] at, logic leg, logic lk, bit xen);
    bit mis = (a % (1 << s)) != 0;
    bit wb  = (at == 2'd0);
    bit ok  = wb || (xen && op == 2'd2 && at == 2'd2);
    if (leg && lk && (!wb || mis)) return 2'd1;
    if (op == 2'd3 || !ok)         return 2'd2;
    if (mis)                       return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [63:0] rd_item(logic [31:0] a);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = mem_b[8'(a[7:0] + 8'(i))];
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exv);
    end
  endtask

  task automatic run_req(logic [1:0] op, logic [31:0] a, logic [1:0] s, logic [1:0] at,
                         logic [63:0] opnd, logic [63:0] cmpv, logic acq, logic leg,
                         logic lk, logic achk);
    logic [63:0] m, old, nv, eold;
    logic [1:0]  ef;
    bit          wr, xp;
    int          m0, x0, cyc, emc;
    m    = szmask(s);
    old  = rd_item(a) & m;
    ef   = ref_fault(op, a, s, at, leg, lk, 1'b1);
    xp   = (ef == 2'd0) && op == 2'd2 && at == 2'd2;
    wr   = 1'b1;
    nv   = opnd & m;
    if (op == 2'd1) wr = (old == (cmpv & m));
    if (op == 2'd2) nv = (old + opnd) & m;
    eold = (ef != 0) ? 64'd0 : (xp ? plat_val(a) : old);
    emc  = (ef != 0 || xp) ? 0 : (wr ? 2 : 1);
    @(negedge clk);
    req_op = op; req_addr = a; req_size = s; req_attr = at; req_operand = opnd;
    req_cmp = cmpv; req_acquire = acq; req_legacy_lock = leg; ctl_lock_icpt = lk;
    req_align_chk = achk; req_valid = 1'b1;
    m0 = mem_cnt; x0 = exp_cnt;
    chk(req_ready == 1'b1, "R1 ready when idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 busy after accept", 64'(req_ready), 64'd0);
    cyc = 1;
    while (!rsp_valid && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    chk(rsp_valid == 1'b1, "R1 response seen", 64'(rsp_valid), 64'd1);
    chk(rsp_fault == ef, "R7 R9 R10 R11 fault code", 64'(rsp_fault), 64'(ef));
    chk(rsp_old == eold, "R2 R3 R4 R8 old value", rsp_old, eold);
    chk(rsp_acquire == ((ef == 0) && (op == 2'd0 || acq)), "R2 R5 acquire",
        64'(rsp_acquire), 64'((ef == 0) && (op == 2'd0 || acq)));
    chk(mem_cnt - m0 == emc, "R6 R12 memory command count", 64'(mem_cnt - m0), 64'(emc));
    chk(exp_cnt - x0 == (xp ? 1 : 0), "R8 export count", 64'(exp_cnt - x0), 64'(xp));
    if (ef != 0) chk(cyc == 1, "R12 fault latency", 64'(cyc), 64'd1);
    if (ef == 0 && !xp && wr)
      chk((rd_item(a) & m) == nv, "R2 R3 R4 stored value", rd_item(a) & m, nv);
    else
      chk((rd_item(a) & m) == old, "R3 R12 memory untouched", rd_item(a) & m, old);
  endtask

  initial begin
    #(CLK_P * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem_b[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(req_ready && !rsp_valid && !mem_cmd_valid && !mem_lock && !exp_valid,
        "R13 reset outputs", {59'd0, req_ready, rsp_valid, mem_cmd_valid, mem_lock, exp_valid}, 64'h10);
    rst_n = 1'b1;

    // Directed corners
    run_req(2'd0, 32'h10, 2'd3, 2'd0, 64'h1122_3344_5566_7788, 0, 0, 0, 0, 0);  // R2
    mem_b[8'h20] = 8'h5A;
    run_req(2'd1, 32'h20, 2'd0, 2'd0, 64'h77, 64'h5A, 1, 0, 0, 0);             // R3 hit
    run_req(2'd1, 32'h20, 2'd0, 2'd0, 64'h99, 64'h5A, 0, 0, 0, 0);             // R3 miss
    mem_b[8'h30] = 8'hFF;
    run_req(2'd2, 32'h30, 2'd0, 2'd0, 64'h1, 0, 1, 0, 0, 0);                   // R4 byte wrap
    run_req(2'd2, 32'h42, 2'd2, 2'd0, 64'h1, 0, 0, 0, 0, 0);                   // R9 chk off
    run_req(2'd2, 32'h42, 2'd2, 2'd0, 64'h1, 0, 0, 0, 0, 1);                   // R9 chk on
    run_req(2'd0, 32'h40, 2'd2, 2'd1, 64'h3, 0, 0, 0, 0, 0);                   // R7 UC
    run_req(2'd2, 32'h40, 2'd2, 2'd3, 64'h3, 0, 0, 0, 0, 0);                   // R7 WC
    run_req(2'd3, 32'h40, 2'd2, 2'd0, 64'h3, 0, 0, 0, 0, 0);                   // R7 op 3
    run_req(2'd0, 32'h40, 2'd2, 2'd2, 64'h3, 0, 0, 0, 0, 0);                   // R7 xchg UCE
    run_req(2'd2, 32'h48, 2'd3, 2'd2, 64'h5, 0, 1, 0, 0, 0);                   // R8 export
    run_req(2'd2, 32'h49, 2'd3, 2'd2, 64'h5, 0, 1, 0, 0, 0);                   // R9 export misaligned
    run_req(2'd0, 32'h50, 2'd1, 2'd1, 64'h3, 0, 0, 1, 1, 0);                   // R10 UC
    run_req(2'd0, 32'h51, 2'd1, 2'd0, 64'h3, 0, 0, 1, 1, 0);                   // R10 misaligned
    run_req(2'd0, 32'h51, 2'd1, 2'd0, 64'h3, 0, 0, 1, 0, 0);                   // R11 ctl off
    run_req(2'd0, 32'h51, 2'd1, 2'd1, 64'h3, 0, 0, 1, 1, 0);                   // R11 lock first
    run_req(2'd0, 32'h51, 2'd1, 2'd1, 64'h3, 0, 0, 0, 0, 0);                   // R11 unsup before unaligned
    run_req(2'd2, 32'h58, 2'd3, 2'd0, 64'h9, 0, 1, 1, 1, 0);                   // R10 legal legacy

    // R8: no export support -> unsupported fault
    @(negedge clk);
    req_op = 2'd2; req_addr = 32'h60; req_size = 2'd2; req_attr = 2'd2;
    req_legacy_lock = 0; ctl_lock_icpt = 0; nx_valid = 1'b1;
    @(negedge clk);
    nx_valid = 1'b0;
    chk(nx_rsp_valid && nx_fault == 2'd2, "R8 no-export fault", 64'(nx_fault), 64'd2);

    // Constrained random
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 16;
      logic [1:0] op = (r < 5) ? 2'd0 : (r < 10) ? 2'd1 : (r < 15) ? 2'd2 : 2'd3;
      logic [1:0] s  = 2'($urandom);
      logic [31:0] a = 32'($urandom % 256);
      int ra = $urandom % 10;
      logic [1:0] at = (ra < 6) ? 2'd0 : 2'($urandom);
      logic [63:0] opnd = {$urandom, $urandom};
      logic [63:0] cv;
      if (($urandom % 10) < 7) a = a & ~32'((1 << s) - 1);
      cv = (($urandom % 2) == 0) ? rd_item(a) : {$urandom, $urandom};
      run_req(op, a, s, at, opnd, cv, 1'($urandom), 1'(($urandom % 5) == 0),
              1'($urandom), 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule